// File: doc/BRIEF.md
# Sigma-Delta Sinc3 Decimator with Selectable Conversion Modes

This block turns the one-bit oversampled stream of an isolated sigma-delta modulator into a 15-bit offset-binary sample. It runs on the modulator's recovered clock, so every rising edge carries one new bit. The block waits for a request on an active-low convert input. It then clears a third-order integrator/comb filter and feeds it exactly three decimation windows of bits. It scales the settled sinc3 value to a common 15-bit range, subtracts a stored offset, clamps the difference to the code range and presents it with a one-cycle ready pulse.

Five conversion modes pick decimation ratios of 1024, 512, 192, 96 and 48 modulator clocks. Longer windows give more effective bits and shorter windows give lower latency. A conversion started with the calibration input high stores the current reading minus mid-scale as the new offset. Offsetting the input leads to the same behaviour as a zero-input measurement after calibration. Because the filter is restarted for every request, a partly filled filter never produces a result.

Top module: `sdm_decimator`

## Requirements
- R1: After reset, `ready` is 0 and `result` reads 0x4000 (mid-scale). The stored offset is zero.
- R2: A conversion starts on the first clock edge at which `conv_n` is sampled low after being sampled high while the block is idle. That edge clears the filter and captures `mode_sel` and `cal_en`. The `mod_bit` values sampled on the next 3·R rising edges are the conversion's input, where R is the decimation ratio of the captured mode.
- R3: `ready` is high for exactly one cycle, following the (3·R+1)-th rising edge after the start edge, and never earlier. `result` changes only together with that pulse and holds its value until the next one.
- R4: The unclamped reading is floor(S·32768 / R³) minus the stored offset. S is the sinc3 sum over the captured bits, with a weight for each bit equal to the number of ways its age in samples (0 = newest) splits into three integers each in 0..R−1.
- R5: `mode_sel` codes 1, 2, 3, 4 and 5 select R = 1024, 512, 192, 96 and 48. Codes 0, 6 and 7 select R = 1024.
- R6: With zero offset, a stream of all ones reads 0x7FFF, all zeros reads 0x0000, and alternating ones and zeros reads 0x4000 in every mode.
- R7: A reading below 0 returns 0x0000 and one above 32767 returns 0x7FFF. Neither case wraps.
- R8: A conversion with `cal_en` captured high stores its scaled reading minus 0x4000 as the offset, which later conversions subtract. Its own `result` reads 0x4000.
- R9: While a conversion is running, falls of `conv_n` and changes of `mode_sel` or `cal_en` have no effect on its timing or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered modulator clock; each rising edge samples one stream bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | One-bit modulator data stream |
| conv_n | input | 1 | Active-low convert request, acted on at its falling edge |
| mode_sel | input | 3 | Conversion mode code (1..5), captured at start |
| cal_en | input | 1 | High at start makes the conversion a calibration |
| result | output | 15 | Corrected, clamped offset-binary sample |
| ready | output | 1 | One-cycle pulse marking a new `result` |

## Verification
A corrupted integrator, comb delay or scaling path does not show until the conversion ends. It then appears as a wrong `result` exactly 3·R+1 edges after the start, so each test compares the full sinc3 value that the bench computes from the stream it drove. A phase or window counter that slips shows at the ports as a `ready` pulse on the wrong edge, which the bench detects by watching every cycle of the conversion. A wrong offset register stays hidden until the next normal conversion, so calibration runs are always followed by readings that force clamping at both rails.

// File: rtl/sdm_dec_pkg.sv
package sdm_dec_pkg;

  localparam int unsigned OUT_W   = 15;
  localparam int unsigned SC_W    = OUT_W + 1;
  localparam int unsigned OFS_W   = OUT_W + 1;
  localparam int unsigned ORDER   = 3;
  localparam int unsigned R_MAX   = 1024;
  localparam int unsigned PH_W    = $clog2(R_MAX);
  localparam int unsigned ACC_W   = ORDER * PH_W + 1;
  localparam int unsigned DEC_W   = $clog2(ORDER);
  localparam int unsigned MIDCODE = 1 << (OUT_W - 1);
  localparam int unsigned DIV_IN_W = 23;

  typedef logic [2:0] mode_idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} seq_state_t;

  // External mode code to internal index; unknown codes use the slowest mode.
  function automatic mode_idx_t decode_mode(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3'd1;
      3'd3:    return 3'd2;
      3'd4:    return 3'd3;
      3'd5:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic int unsigned ratio_of(input mode_idx_t idx);
    case (idx)
      3'd1:    return 512;
      3'd2:    return 192;
      3'd3:    return 96;
      3'd4:    return 48;
      default: return R_MAX;
    endcase
  endfunction

  function automatic logic [PH_W-1:0] last_phase(input mode_idx_t idx);
    return PH_W'(ratio_of(idx) - 1);
  endfunction

  // Exact floor(y/27) for y below 2^23 via a 32-bit-shifted reciprocal.
  function automatic logic [SC_W-1:0] div_by_27(input logic [DIV_IN_W-1:0] y);
    logic [50:0] prod;
    prod = {28'd0, y} * 51'd159072863;
    return prod[47:32];
  endfunction

  // Map a raw sinc3 value in [0, R^3] onto [0, 32768].
  function automatic logic [SC_W-1:0] scale_raw(input logic [ACC_W-1:0] raw,
                                                input mode_idx_t idx);
    case (idx)
      3'd1:    return SC_W'(raw >> 12);                     // 2^27 -> 2^15
      3'd2:    return div_by_27(DIV_IN_W'(raw >> 3));       // /216
      3'd3:    return div_by_27(DIV_IN_W'(raw));            // /27
      3'd4:    return div_by_27(DIV_IN_W'(raw << 3));       // *8/27
      default: return SC_W'(raw >> 15);                     // 2^30 -> 2^15
    endcase
  endfunction

  function automatic logic signed [OFS_W-1:0] cal_offset(input logic [SC_W-1:0] sc);
    logic [SC_W:0] d;
    d = {1'b0, sc} - (SC_W+1)'(MIDCODE);
    return $signed(d[OFS_W-1:0]);
  endfunction

  // Subtract the offset, then clamp to the unsigned output range.
  function automatic logic [OUT_W-1:0] apply_offset(input logic [SC_W-1:0] sc,
                                                    input logic signed [OFS_W-1:0] ofs);
    logic [OUT_W+2:0] d;
    d = {2'b00, sc} - {{2{ofs[OFS_W-1]}}, ofs};
    if (d[OUT_W+2])               return '0;
    else if (d[OUT_W+1] | d[OUT_W]) return '1;
    else                           return d[OUT_W-1:0];
  endfunction

endpackage

// File: rtl/sdm_dec_ctrl.sv
module sdm_dec_ctrl
  import sdm_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      conv_n,
  input  logic [2:0] mode_sel,
  input  logic      cal_en,
  output logic      clear_o,
  output logic      sample_o,
  output logic      fire_o,
  output logic      finish_o,
  output logic      cal_o,
  output mode_idx_t midx_o
);

  seq_state_t        state;
  logic              conv_prev;
  logic [PH_W-1:0]   ph;
  logic [DEC_W-1:0]  dec;
  mode_idx_t         midx_q;
  logic              cal_q;

  logic busy, start, at_edge, last;

  assign busy    = (state != ST_IDLE);
  assign start   = conv_prev & ~conv_n & ~busy;
  assign at_edge = (state == ST_RUN) && (ph == last_phase(midx_q));
  assign last    = at_edge && (dec == DEC_W'(ORDER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      conv_prev <= 1'b1;
      ph        <= '0;
      dec       <= '0;
      midx_q    <= '0;
      cal_q     <= 1'b0;
    end else begin
      conv_prev <= conv_n;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          ph     <= '0;
          dec    <= '0;
          midx_q <= decode_mode(mode_sel);
          cal_q  <= cal_en;
        end
        ST_RUN: begin
          if (at_edge) begin
            ph  <= '0;
            dec <= dec + DEC_W'(1);
            if (last) state <= ST_FINISH;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign clear_o  = start;
  assign sample_o = (state == ST_RUN);
  assign fire_o   = at_edge;
  assign finish_o = (state == ST_FINISH);
  assign cal_o    = cal_q;
  assign midx_o   = midx_q;

  // R3: the post stage gets exactly one finish cycle per conversion
  assert_finish_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINISH) |=> (state == ST_IDLE));

  // R9: a convert request during a conversion leaves the captured setup alone
  assert_setup_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_prev && !conv_n) |=> ($stable(midx_q) && $stable(cal_q) && busy));

  // R2: the phase counter stays inside the captured window
  assert_phase_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (ph <= last_phase(midx_q)));

endmodule

// File: rtl/sdm_dec_sinc3.sv
module sdm_dec_sinc3
  import sdm_dec_pkg::*;
#(
  parameter int unsigned W = ACC_W,
  parameter int unsigned N = ORDER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample_en,
  input  logic         fire,
  input  logic         din,
  output logic [W-1:0] raw_o
);

  logic [W-1:0] integ_q [N];
  logic [W-1:0] integ_d [N];
  logic [W-1:0] dly_q   [N];
  logic [W-1:0] comb_in [N];
  logic [W-1:0] comb_v  [N];

  for (genvar s = 0; s < N; s++) begin : g_stage
    logic [W-1:0] iq, dq;

    if (s == 0) begin : g_first
      assign integ_d[s] = iq + W'(din);
      assign comb_in[s] = integ_d[N-1];
    end else begin : g_rest
      assign integ_d[s] = iq + integ_d[s-1];
      assign comb_in[s] = comb_v[s-1];
    end
    assign comb_v[s]  = comb_in[s] - dq;
    assign integ_q[s] = iq;
    assign dly_q[s]   = dq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        iq <= '0;
        dq <= '0;
      end else if (clear) begin
        iq <= '0;
        dq <= '0;
      end else if (sample_en) begin
        iq <= integ_d[s];
        if (fire) dq <= comb_in[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 raw_o <= '0;
    else if (clear)             raw_o <= '0;
    else if (sample_en && fire) raw_o <= comb_v[N-1];
  end

  // R2: a cleared filter starts its first sample from zero state
  assert_cleared_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (integ_q[0] == '0 && dly_q[N-1] == '0));

endmodule

// File: rtl/sdm_dec_post.sv
module sdm_dec_post
  import sdm_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic             cal,
  input  mode_idx_t        midx,
  input  logic [ACC_W-1:0] raw,
  output logic [OUT_W-1:0] result,
  output logic             ready
);

  logic [SC_W-1:0]         scaled;
  logic signed [OFS_W-1:0] ofs_q;
  logic signed [OFS_W-1:0] ofs_next;

  assign scaled   = scale_raw(raw, midx);
  assign ofs_next = cal ? cal_offset(scaled) : ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      result <= OUT_W'(MIDCODE);
      ready  <= 1'b0;
    end else begin
      ready <= finish;
      if (finish) begin
        ofs_q  <= ofs_next;
        result <= apply_offset(scaled, ofs_next);
      end
    end
  end

  // R3: ready is a single-cycle pulse
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R3: result moves only when a conversion completes
  assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

  // R8: a calibration conversion reads mid-scale
  assert_cal_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cal) |-> (result == OUT_W'(MIDCODE)));

endmodule

// File: rtl/sdm_decimator.sv
module sdm_decimator
  import sdm_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic             conv_n,
  input  logic [2:0]       mode_sel,
  input  logic             cal_en,
  output logic [OUT_W-1:0] result,
  output logic             ready
);

  logic             clear, sample, fire, finish, cal;
  mode_idx_t        midx;
  logic [ACC_W-1:0] raw;

  sdm_dec_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_n   (conv_n),
    .mode_sel (mode_sel),
    .cal_en   (cal_en),
    .clear_o  (clear),
    .sample_o (sample),
    .fire_o   (fire),
    .finish_o (finish),
    .cal_o    (cal),
    .midx_o   (midx)
  );

  sdm_dec_sinc3 #(.W(ACC_W), .N(ORDER)) u_sinc3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .sample_en (sample),
    .fire      (fire),
    .din       (mod_bit),
    .raw_o     (raw)
  );

  sdm_dec_post u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .finish (finish),
    .cal    (cal),
    .midx   (midx),
    .raw    (raw),
    .result (result),
    .ready  (ready)
  );

  // R2: clearing and sampling never coincide
  assert_no_sample_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && sample));

  // R3: every ready pulse follows a finish cycle of the sequencer
  assert_ready_after_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(finish));

endmodule

// File: tb/test_sdm_decimator.sv
`timescale 1ns/1ps
module test_sdm_decimator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic        conv_n = 1'b1;
  logic [2:0]  mode_sel = 3'd1;
  logic        cal_en = 1'b0;
  logic [14:0] result;
  logic        ready;

  int     checks = 0;
  int     fails = 0;
  longint ofs_model = 0;
  bit     stream [0:3071];

  sdm_decimator i_sdm_decimator (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_bit  (mod_bit),
    .conv_n   (conv_n),
    .mode_sel (mode_sel),
    .cal_en   (cal_en),
    .result   (result),
    .ready    (ready)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL R3 watchdog: conversion never completed, got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic int ratio_for(input logic [2:0] sel);
    case (sel)
      3'd2: return 512;
      3'd3: return 192;
      3'd4: return 96;
      3'd5: return 48;
      default: return 1024;
    endcase
  endfunction

  // Number of (a,b,c) in [0,R)^3 with a+b+c == j.
  function automatic longint weight(input int r, input int j);
    longint w = 0;
    for (int a = 0; a < r; a++) begin
      int m = j - a;
      if (m >= 0 && m <= 2*r - 2) w += (m < r) ? m + 1 : 2*r - 1 - m;
    end
    return w;
  endfunction

  function automatic longint raw_expect(input int r);
    longint s = 0;
    for (int j = 0; j <= 3*r - 3; j++)
      if (stream[3*r - 1 - j]) s += weight(r, j);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kind 0: random with P(1)=p/256, 1: all ones, 2: all zeros, 3: alternating
  task automatic fill(input int kind, input int p);
    for (int k = 0; k < 3072; k++) begin
      case (kind)
        1: stream[k] = 1'b1;
        2: stream[k] = 1'b0;
        3: stream[k] = k[0];
        default: stream[k] = (($urandom % 256) < p);
      endcase
    end
  endtask

  task automatic run_conv(input logic [2:0] sel, input bit cal, input bit disturb,
                          input string req);
    int     r;
    longint raw, sc, corr;
    bit     early;
    r = ratio_for(sel);
    early = 1'b0;
    raw = raw_expect(r);
    sc = (raw * 32768) / (longint'(r) * r * r);
    if (cal) ofs_model = sc - 16384;
    corr = sc - ofs_model;
    if (corr < 0) corr = 0;
    if (corr > 32767) corr = 32767;

    @(negedge clk);
    mode_sel = sel;
    cal_en = cal;
    conv_n = 1'b0;
    @(posedge clk);
    for (int k = 0; k < 3*r; k++) begin
      @(negedge clk);
      if (ready) early = 1'b1;
      conv_n = (disturb && k == 5) ? 1'b0 : 1'b1;
      if (disturb && k == 5) begin
        mode_sel = (sel == 3'd5) ? 3'd1 : 3'd5;
        cal_en = ~cal;
      end
      mod_bit = stream[k];
    end
    @(negedge clk);
    if (ready) early = 1'b1;
    check(!early, "R3", "ready before window filled", longint'(early), 0);
    @(negedge clk);
    check(ready == 1'b1, "R3", "ready after 3R+1 edges", longint'(ready), 1);
    check(result == corr, req, "result", longint'(result), corr);
    @(negedge clk);
    check(ready == 1'b0, "R3", "ready pulse width", longint'(ready), 0);
    check(result == corr, "R3", "result held", longint'(result), corr);
    mode_sel = sel;
    cal_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    check(ready == 1'b0, "R1", "ready after reset", longint'(ready), 0);
    check(result == 15'h4000, "R1", "result after reset", longint'(result), 16384);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 / R5: alternating stream reads mid-scale in every mode
    fill(3, 0);
    for (int m = 1; m <= 5; m++) run_conv(3'(m), 1'b0, 1'b0, "R6");

    // R6: rails
    fill(1, 0); run_conv(3'd5, 1'b0, 1'b0, "R6");
    fill(2, 0); run_conv(3'd5, 1'b0, 1'b0, "R6");
    fill(1, 0); run_conv(3'd2, 1'b0, 1'b0, "R6");

    // R4: random densities in every mode
    for (int m = 1; m <= 5; m++) begin
      fill(0, 20 + 45 * m);
      run_conv(3'(m), 1'b0, 1'b0, "R4");
    end

    // R5: unused codes fall back to the 1024 window
    fill(0, 170); run_conv(3'd0, 1'b0, 1'b0, "R5");
    fill(0, 90);  run_conv(3'd7, 1'b0, 1'b0, "R5");

    // R9: disturbances during a conversion
    fill(0, 140); run_conv(3'd3, 1'b0, 1'b1, "R9");
    fill(0, 60);  run_conv(3'd5, 1'b1, 1'b1, "R9");
    fill(3, 0);   run_conv(3'd4, 1'b1, 1'b0, "R8");

    // R8: calibrate on a positive input, then read a different one
    fill(0, 190); run_conv(3'd4, 1'b1, 1'b0, "R8");
    fill(0, 150); run_conv(3'd4, 1'b0, 1'b0, "R8");
    // R7: positive offset pushes an all-zero reading below the rail
    fill(2, 0);   run_conv(3'd5, 1'b0, 1'b0, "R7");

    // R7: negative offset pushes an all-one reading above the rail
    fill(0, 60);  run_conv(3'd5, 1'b1, 1'b0, "R8");
    fill(1, 0);   run_conv(3'd4, 1'b0, 1'b0, "R7");
    fill(0, 100); run_conv(3'd3, 1'b0, 1'b0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule